// File: doc/BRIEF.md
# Multichannel Audio Sample FIFO

This block sits between a register-mapped processor port and a serial audio engine and buffers 24-bit sample words for one transfer direction. A strap input picks the direction. When it is set to output, software writes samples into the data register and the serializer takes them out. When it is set to input, the serializer pushes samples in and software reads them from the data register. The storage holds 256 words shifted left by a size parameter. The usable part depends on the configured channel count: the depth per channel is the storage size halved once for every doubling the channel count needs, and the storage is then shared by the channels of each frame.

Software sees three registers. The control register holds a half-level interrupt enable and a self-clearing flush bit. The status register reports the fill level in whole frames, which are per-channel sample units, and holds two sticky error flags. The data register is the sample port. Only the low 24 bits of a write are kept. A 16-bit sample is carried left-aligned in bits 23:8 and comes back out in the same position.

Top module: `audio_sample_fifo`

## Requirements
- R1: The per-channel depth is (256 << SIZE_CODE) halved once for each doubling from 1 up to the channel count, so 3 channels use the 4-channel depth and 5 to 7 use the 8-channel depth. The FIFO is full when it holds depth × channels words.
- R2: Status bits 16:8 (address 1) report the fill level as the number of stored words divided by the channel count, rounded down, and saturate at 511.
- R3: A push while full is dropped and sets status bit 4. The bit stays set until a status write with bit 4 at 0 clears it, and a status write with bit 4 at 1 leaves it set.
- R4: A pop while empty returns zero, changes nothing else and sets status bit 0. The bit clears the same way, through a status write with bit 0 at 0.
- R5: Writing 1 to control bit 0 (address 0) makes that bit read 1 for one cycle. On the following clock edge the FIFO empties and the bit returns to 0.
- R6: Control bit 20 enables half_irq. In the output direction half_irq is high while the fill level is at or below half the per-channel depth, and it is low whenever bit 20 is 0.
- R7: In the input direction an enabled half_irq is high while the fill level is at or above half the per-channel depth.
- R8: In the output direction, writes to the data register (address 2) push and ser_pop pops, with ser_rdata showing the oldest word. ser_push has no effect there, and data-register reads return 0 without popping. In the input direction, ser_push pushes and data-register reads return the oldest word and pop it. Data-register writes and ser_pop have no effect there, and ser_rdata is 0.
- R9: Bits 31:24 of a write are discarded and reads return 0 in bits 31:24. A 16-bit sample written in bits 23:8 is returned unchanged in bits 23:8.
- R10: Words leave in the order they entered, including across the wrap of the storage.
- R11: After reset the control and status registers read 0, the FIFO is empty and half_irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dir_out | input | 1 | 1: processor fills and serializer drains; 0: the reverse |
| cfg_chan_m1 | input | 3 | Channel count minus one (1 to 8 channels) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a data read pops in the input direction) |
| reg_addr | input | 2 | 0 control, 1 status, 2 data, 3 reserved |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| ser_push | input | 1 | Serializer push (input direction) |
| ser_wdata | input | 24 | Serializer sample to push |
| ser_pop | input | 1 | Serializer pop (output direction) |
| ser_rdata | output | 24 | Oldest word, shown to the serializer in the output direction |
| half_irq | output | 1 | Level-sensitive half-level interrupt request |

## Verification
The assertions watch, on every cycle, that the word count never exceeds the capacity, that a push into a full FIFO leaves the count unchanged and raises the overrun flag, that a pop from an empty FIFO raises the underrun flag, that both flags stay set until a matching status write, that a flush always leaves the FIFO empty, and that half_irq stays low while it is disabled. Only the bench scenarios can show the depth for each of the eight channel counts, the rounded-down frame count, the first-in-first-out order across the wrap, the direction routing, the 24-bit masking and the half-level thresholds in both directions.

// File: rtl/afs_pkg.sv
package afs_pkg;

  localparam int unsigned BASE_WORDS = 256;
  localparam int DATA_W        = 24;
  localparam int FILL_W        = 9;
  localparam int CTRL_FLUSH    = 0;
  localparam int CTRL_HALF_EN  = 20;
  localparam int STAT_UDR      = 0;
  localparam int STAT_OVR      = 4;
  localparam int STAT_FILL_LSB = 8;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_DATA = 2'd2,
    ADDR_RSVD = 2'd3
  } afs_addr_e;

  // Number of halvings: ceil(log2(channel count)).
  function automatic logic [1:0] chan_shift(input logic [2:0] chm1);
    logic [1:0] s;
    unique case (chm1)
      3'd0:       s = 2'd0;
      3'd1:       s = 2'd1;
      3'd2, 3'd3: s = 2'd2;
      default:    s = 2'd3;
    endcase
    return s;
  endfunction

  // Whole frames held by a number of words.
  function automatic logic [15:0] frames_of(input logic [15:0] words,
                                            input logic [2:0]  chm1);
    return words / ({13'd0, chm1} + 16'd1);
  endfunction

endpackage

// File: rtl/afs_geom.sv
module afs_geom #(
  parameter int SIZE_CODE = 0,
  parameter int CW        = 9
) (
  input  logic [2:0]    chm1,
  output logic [CW-1:0] cap_words,
  output logic [15:0]   depth_frames,
  output logic [15:0]   half_frames
);
  localparam int unsigned TOTAL   = afs_pkg::BASE_WORDS << SIZE_CODE;
  localparam logic [15:0] TOTAL16 = 16'(TOTAL);

  logic [15:0] cap16;

  always_comb begin
    depth_frames = TOTAL16 >> afs_pkg::chan_shift(chm1);
    half_frames  = depth_frames >> 1;
    cap16        = depth_frames * ({13'd0, chm1} + 16'd1);
    cap_words    = CW'(cap16);
  end
endmodule

// File: rtl/afs_ring.sv
module afs_ring #(
  parameter int AW = 8,
  parameter int CW = 9,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  input  logic [CW-1:0] cap_words,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_drop,
  output logic          pop_miss
);
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p,
                                         input logic [CW-1:0] lim);
    return ({1'b0, p} == lim - 1'b1) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count >= cap_words);
  assign empty     = (count == '0);
  assign push_ok   = push & ~full  & ~flush;
  assign pop_ok    = pop  & ~empty & ~flush;
  assign push_drop = push &  full  & ~flush;
  assign pop_miss  = pop  &  empty & ~flush;
  assign head      = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr, cap_words);
      if (pop_ok)  rd_ptr <= step(rd_ptr, cap_words);
      unique case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo #(
  parameter int SIZE_CODE = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_dir_out,
  input  logic [2:0]  cfg_chan_m1,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ser_push,
  input  logic [23:0] ser_wdata,
  input  logic        ser_pop,
  output logic [23:0] ser_rdata,
  output logic        half_irq
);
  import afs_pkg::*;

  localparam int unsigned TOTAL = BASE_WORDS << SIZE_CODE;
  localparam int AW = $clog2(TOTAL);
  localparam int CW = AW + 1;

  // Named internal events, also used by the bound checker.
  logic              wr_ctrl, wr_stat, wr_data, rd_data;
  logic              push_req, pop_req;
  logic [DATA_W-1:0] push_word, head;
  logic [CW-1:0]     count, cap_words;
  logic              full, empty, push_drop, pop_miss;
  logic [15:0]       depth_frames, half_frames, fill16;
  logic [FILL_W-1:0] fill_rep;
  logic              level_hit;
  logic              half_en, flush_q, ovr_q, udr_q;
  logic              unused_hi;

  assign unused_hi = ^reg_wdata[31:24];

  assign wr_ctrl = reg_wr & (reg_addr == ADDR_CTRL);
  assign wr_stat = reg_wr & (reg_addr == ADDR_STAT);
  assign wr_data = reg_wr & (reg_addr == ADDR_DATA);
  assign rd_data = reg_rd & (reg_addr == ADDR_DATA);

  assign push_req  = cfg_dir_out ? wr_data : ser_push;
  assign push_word = cfg_dir_out ? reg_wdata[DATA_W-1:0] : ser_wdata;
  assign pop_req   = cfg_dir_out ? ser_pop : rd_data;

  afs_geom #(.SIZE_CODE(SIZE_CODE), .CW(CW)) u_geom (
    .chm1        (cfg_chan_m1),
    .cap_words   (cap_words),
    .depth_frames(depth_frames),
    .half_frames (half_frames)
  );

  afs_ring #(.AW(AW), .CW(CW), .DW(DATA_W)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush_q),
    .push     (push_req),
    .wdata    (push_word),
    .pop      (pop_req),
    .cap_words(cap_words),
    .head     (head),
    .count    (count),
    .full     (full),
    .empty    (empty),
    .push_drop(push_drop),
    .pop_miss (pop_miss)
  );

  assign fill16    = frames_of(16'(count), cfg_chan_m1);
  assign fill_rep  = (fill16 > 16'd511) ? 9'h1FF : fill16[FILL_W-1:0];
  assign level_hit = cfg_dir_out ? (fill16 <= half_frames) : (fill16 >= half_frames);
  assign half_irq  = half_en & level_hit;
  assign ser_rdata = cfg_dir_out ? head : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_en <= 1'b0;
      flush_q <= 1'b0;
      ovr_q   <= 1'b0;
      udr_q   <= 1'b0;
    end else begin
      flush_q <= wr_ctrl & reg_wdata[CTRL_FLUSH];
      if (wr_ctrl) half_en <= reg_wdata[CTRL_HALF_EN];
      if (push_drop)                         ovr_q <= 1'b1;
      else if (wr_stat && !reg_wdata[STAT_OVR]) ovr_q <= 1'b0;
      if (pop_miss)                          udr_q <= 1'b1;
      else if (wr_stat && !reg_wdata[STAT_UDR]) udr_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_CTRL: begin
        reg_rdata[CTRL_HALF_EN] = half_en;
        reg_rdata[CTRL_FLUSH]   = flush_q;
      end
      ADDR_STAT: begin
        reg_rdata[STAT_FILL_LSB +: FILL_W] = fill_rep;
        reg_rdata[STAT_OVR]                = ovr_q;
        reg_rdata[STAT_UDR]                = udr_q;
      end
      ADDR_DATA: reg_rdata[DATA_W-1:0] = cfg_dir_out ? '0 : head;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/audio_sample_fifo_chk.sv
module audio_sample_fifo_chk #(
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_req,
  input logic          pop_req,
  input logic          full,
  input logic          empty,
  input logic          flush,
  input logic [CW-1:0] count,
  input logic [CW-1:0] cap_words,
  input logic          ovr,
  input logic          udr,
  input logic          wr_stat,
  input logic          ovr_wbit,
  input logic          udr_wbit,
  input logic          half_en,
  input logic          half_irq
);
  // R1
  cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= cap_words);

  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop_req && !flush) |=> (count == $past(count)) && ovr);

  // R3
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !(wr_stat && !ovr_wbit)) |=> ovr);

  // R4
  empty_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty && !flush) |=> udr);

  // R4
  udr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (udr && !(wr_stat && !udr_wbit)) |=> udr);

  // R5
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !half_en |-> !half_irq);
endmodule

bind audio_sample_fifo audio_sample_fifo_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .push_req (push_req),
  .pop_req  (pop_req),
  .full     (full),
  .empty    (empty),
  .flush    (flush_q),
  .count    (count),
  .cap_words(cap_words),
  .ovr      (ovr_q),
  .udr      (udr_q),
  .wr_stat  (wr_stat),
  .ovr_wbit (reg_wdata[4]),
  .udr_wbit (reg_wdata[0]),
  .half_en  (half_en),
  .half_irq (half_irq)
);

// File: tb/audio_sample_fifo_tb.sv
module audio_sample_fifo_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_dir_out = 1'b1;
  logic [2:0]  cfg_chan_m1 = 3'd0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ser_push = 1'b0, ser_pop = 1'b0;
  logic [23:0] ser_wdata = '0;
  logic [23:0] ser_rdata;
  logic        half_irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  audio_sample_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_dir_out(cfg_dir_out), .cfg_chan_m1(cfg_chan_m1),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ser_push(ser_push), .ser_wdata(ser_wdata),
    .ser_pop(ser_pop), .ser_rdata(ser_rdata), .half_irq(half_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // All helpers start and end at a falling edge.
  task automatic cpu_wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic cpu_rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic s_push(input logic [23:0] d);
    ser_wdata = d; ser_push = 1'b1;
    @(negedge clk);
    ser_push = 1'b0;
  endtask

  task automatic s_pop(output logic [23:0] v);
    ser_pop = 1'b1;
    #1 v = ser_rdata;
    @(negedge clk);
    ser_pop = 1'b0;
  endtask

  task automatic get_fill(output int f);
    logic [31:0] v;
    cpu_rd(2'd1, v);
    f = int'((v >> 8) & 32'h1FF);
  endtask

  task automatic get_stat(output logic [31:0] v);
    cpu_rd(2'd1, v);
  endtask

  task automatic flush_fifo(input logic keep_half);
    cpu_wr(2'd0, (32'(keep_half) << 20) | 32'd1);
    @(negedge clk);
  endtask

  function automatic int exp_depth(input int chans);
    int d = 256;
    int c = 1;
    while (c < chans) begin d = d / 2; c = c * 2; end
    return d;
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    cpu_rd(2'd0, v); chk("R11 ctrl after reset", v, 32'h0);
    cpu_rd(2'd1, v); chk("R11 status after reset", v, 32'h0);
    chk("R11 half_irq after reset", 32'(half_irq), 32'h0);
    #1 chk("R11 ser_rdata empty", 32'(ser_rdata), 32'h0);
  endtask

  task automatic t_out_path();
    logic [31:0] v;
    logic [23:0] s;
    int f;
    cfg_dir_out = 1'b1; cfg_chan_m1 = 3'd0;
    cpu_wr(2'd2, 32'hAB123456);
    cpu_wr(2'd2, {8'h00, 16'hBEEF, 8'h00});
    s_push(24'h777777);
    get_fill(f); chk("R8 ser_push ignored in output dir", 32'(f), 32'd2);
    cpu_rd(2'd2, v); chk("R8 data read in output dir returns 0", v, 32'h0);
    get_fill(f); chk("R8 data read does not pop in output dir", 32'(f), 32'd2);
    s_pop(s); chk("R9 high byte of write discarded", 32'(s), 32'h123456);
    s_pop(s); chk("R9 16-bit sample kept in 23:8 (R10 order)", 32'(s), 32'hBEEF00);
    get_fill(f); chk("R8 serializer pops drained", 32'(f), 32'd0);
  endtask

  task automatic t_overrun_wrap();
    logic [31:0] v;
    logic [23:0] s;
    int f;
    int bad = 0;
    cfg_dir_out = 1'b1; cfg_chan_m1 = 3'd0;
    for (int i = 0; i < 256; i++) cpu_wr(2'd2, 32'(i));
    get_stat(v);
    chk("R2 fill 256 at bits 16:8", (v >> 8) & 32'h1FF, 32'd256);
    chk("R3 no overrun at capacity", v & 32'h11, 32'h0);
    cpu_wr(2'd2, 32'hFFFFFF);
    get_stat(v);
    chk("R3 overrun set on full push", v & 32'h11, 32'h10);
    chk("R3 dropped push leaves fill", (v >> 8) & 32'h1FF, 32'd256);
    cpu_wr(2'd1, 32'h10);
    get_stat(v); chk("R3 write with bit4=1 keeps overrun", v & 32'h10, 32'h10);
    cpu_wr(2'd1, 32'h0);
    get_stat(v); chk("R3 write 0 clears overrun", v & 32'h11, 32'h0);
    for (int i = 0; i < 100; i++) begin
      s_pop(s);
      if (s !== 24'(i)) bad++;
    end
    for (int i = 0; i < 100; i++) cpu_wr(2'd2, 32'(1000 + i));
    for (int i = 100; i < 256; i++) begin
      s_pop(s);
      if (s !== 24'(i)) bad++;
    end
    for (int i = 0; i < 100; i++) begin
      s_pop(s);
      if (s !== 24'(1000 + i)) bad++;
    end
    chk("R10 order across wrap (mismatches)", 32'(bad), 32'd0);
    s_pop(s); chk("R4 pop on empty returns 0", 32'(s), 32'h0);
    get_stat(v);
    chk("R4 underrun set", v & 32'h11, 32'h01);
    get_fill(f); chk("R4 empty pop leaves fill 0", 32'(f), 32'd0);
    cpu_wr(2'd1, 32'h0);
    get_stat(v); chk("R4 write 0 clears underrun", v & 32'h11, 32'h0);
  endtask

  task automatic t_flush();
    logic [31:0] c0, s0, c1, s1;
    cfg_dir_out = 1'b1; cfg_chan_m1 = 3'd0;
    for (int i = 0; i < 5; i++) cpu_wr(2'd2, 32'(i));
    cpu_wr(2'd0, 32'h1);
    reg_addr = 2'd0; #1 c0 = reg_rdata;
    reg_addr = 2'd1; #1 s0 = reg_rdata;
    @(negedge clk);
    reg_addr = 2'd0; #1 c1 = reg_rdata;
    reg_addr = 2'd1; #1 s1 = reg_rdata;
    chk("R5 flush bit reads 1 one cycle", c0 & 32'h1, 32'h1);
    chk("R5 fill kept until flush edge", (s0 >> 8) & 32'h1FF, 32'd5);
    chk("R5 flush bit self-clears", c1 & 32'h1, 32'h0);
    chk("R5 FIFO empty after flush", (s1 >> 8) & 32'h1FF, 32'd0);
    @(negedge clk);
  endtask

  task automatic t_geometry();
    logic [31:0] v;
    int f;
    cfg_dir_out = 1'b1;
    for (int ch = 1; ch <= 8; ch++) begin
      int depth = exp_depth(ch);
      int cap = depth * ch;
      cfg_chan_m1 = 3'(ch - 1);
      @(negedge clk);
      for (int i = 0; i < cap - 1; i++) cpu_wr(2'd2, 32'(i));
      get_fill(f); chk($sformatf("R2 floor fill ch=%0d", ch), 32'(f), 32'((cap - 1) / ch));
      cpu_wr(2'd2, 32'h1);
      get_stat(v);
      chk($sformatf("R1 depth ch=%0d", ch), (v >> 8) & 32'h1FF, 32'(depth));
      chk($sformatf("R1 no overrun at cap ch=%0d", ch), v & 32'h10, 32'h0);
      cpu_wr(2'd2, 32'h2);
      get_stat(v);
      chk($sformatf("R1 full beyond cap ch=%0d", ch), v & 32'h10, 32'h10);
      cpu_wr(2'd1, 32'h0);
      flush_fifo(1'b0);
    end
    cfg_chan_m1 = 3'd0;
    @(negedge clk);
  endtask

  task automatic t_half_out();
    cfg_dir_out = 1'b1; cfg_chan_m1 = 3'd1;
    cpu_wr(2'd0, 32'h0010_0000);
    chk("R6 empty output raises half_irq", 32'(half_irq), 32'h1);
    for (int i = 0; i < 129; i++) cpu_wr(2'd2, 32'(i));
    chk("R6 64 frames (half) keeps half_irq", 32'(half_irq), 32'h1);
    cpu_wr(2'd2, 32'h0);
    chk("R6 65 frames drops half_irq", 32'(half_irq), 32'h0);
    flush_fifo(1'b0);
    chk("R6 disabled half_irq stays low", 32'(half_irq), 32'h0);
    cfg_chan_m1 = 3'd0;
    @(negedge clk);
  endtask

  task automatic t_input();
    logic [31:0] v;
    logic [23:0] s;
    int f;
    int bad = 0;
    cfg_dir_out = 1'b0; cfg_chan_m1 = 3'd0;
    @(negedge clk);
    cpu_wr(2'd0, 32'h0010_0000);
    chk("R7 empty input keeps half_irq low", 32'(half_irq), 32'h0);
    for (int i = 0; i < 127; i++) s_push(24'(32'h100 + i));
    chk("R7 below half keeps half_irq low", 32'(half_irq), 32'h0);
    s_push(24'(32'h100 + 127));
    chk("R7 at half raises half_irq", 32'(half_irq), 32'h1);
    cpu_wr(2'd2, 32'h55);
    get_fill(f); chk("R8 data write ignored in input dir", 32'(f), 32'd128);
    s_pop(s);
    chk("R8 ser_rdata is 0 in input dir", 32'(s), 32'h0);
    get_fill(f); chk("R8 ser_pop ignored in input dir", 32'(f), 32'd128);
    cpu_rd(2'd2, v); chk("R8 data read returns oldest", v, 32'h100);
    chk("R7 below half after read", 32'(half_irq), 32'h0);
    for (int i = 1; i < 128; i++) begin
      cpu_rd(2'd2, v);
      if (v !== 32'(32'h100 + i)) bad++;
    end
    chk("R10 input order (mismatches)", 32'(bad), 32'd0);
    cpu_rd(2'd2, v); chk("R4 read on empty returns 0", v, 32'h0);
    get_stat(v); chk("R4 underrun from data read", v & 32'h11, 32'h01);
    cpu_wr(2'd1, 32'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_out_path();
    t_overrun_wrap();
    t_flush();
    t_geometry();
    t_half_out();
    t_input();
    summary();
    $finish;
  end
endmodule